// File: doc/BRIEF.md
# Scrambled Program Memory Readout

This block sits between an 8-bit program memory and a parallel verify port. Each byte read out is scrambled. The block holds a table of 64 key bytes. For a read, it takes the key byte picked by the low six address bits, inverts it, and XORs it with the stored byte. A blank table holds 0xFF in every slot, so a blank table passes data through unchanged.

The key bytes are loaded one at a time through a programming port. As in blank-state storage, a write can only clear bits. One erase pulse returns all 64 key slots to 0xFF. A read request is accepted on a clock edge, and the scrambled byte appears with a valid flag in the next cycle. The program memory is a plain internal RAM with a write port, so a test environment can load it. The scrambling has a known weakness: a stored byte of 0xFF reads out as the raw key byte for its slot.

Top module: `code_scrambler`

## Requirements
- R1: A read of address A returns mem[A] XOR (NOT key[A mod 64]).
- R2: The key slot is the low 6 bits of the 12-bit address, so addresses 64 bytes apart share one key slot across the whole space (for example 0x003 and 0xFC3).
- R3: One cycle of `erase` sets all 64 key slots to 0xFF. After that, reads return stored bytes unchanged.
- R4: When `rd_req` is sampled high on an edge, `rd_valid` is 1 and `rd_data` holds the result after that edge. When `rd_req` is low, `rd_valid` is 0 after the edge and `rd_data` keeps its value.
- R5: A key write is dropped when `rd_req` is high in the same cycle.
- R6: A key write stores old AND written value, so bits only go from 1 to 0 between erases.
- R7: A stored byte of 0xFF reads out as the raw key byte of its slot.
- R8: A synchronous active-high `rst` clears `rd_valid` and `rd_data` to 0. It leaves the key and memory contents as they were.
- R9: If `erase` and a key write fall in the same cycle, the erase wins and the slot ends at 0xFF.
- R10: A read in the same cycle as `erase` uses the key values from before the erase.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| mem_we | input | 1 | Program memory write enable |
| mem_waddr | input | 12 | Program memory write address |
| mem_wdata | input | 8 | Program memory write byte |
| key_we | input | 1 | Key slot write enable |
| key_idx | input | 6 | Key slot index |
| key_wdata | input | 8 | Key byte, ANDed into the slot |
| erase | input | 1 | Returns every key slot to 0xFF |
| rd_req | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_data | output | 8 | Scrambled read byte |
| rd_valid | output | 1 | High for one cycle after an accepted request |

## Verification
Two pairs of operations can land in the same cycle. A key write can coincide with a read request, and an erase can coincide with a read or with a key write. The bench drives each pair on one clock edge.

For the write-during-read case, the same slot is read again afterwards. The bench checks that the key did not change (R5).

For the erase-during-read case, the bench checks that the read returned the pre-erase scrambling (R10). It then reads again and expects passthrough.

For the erase-with-write case, a follow-up read must show the slot at 0xFF (R9).

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 12;
    localparam int KEY_IDX_W = 6;
    localparam int KEY_SLOTS = 1 << KEY_IDX_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/scr_key_table.sv
module scr_key_table
    import scr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 erase,
    input  logic                 wr_en,
    input  logic [KEY_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_busy,
    input  logic [KEY_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_key
);
    logic [DATA_W-1:0] key_q [KEY_SLOTS];
    logic [DATA_W-1:0] key_d [KEY_SLOTS];
    logic              wr_ok;

    assign wr_ok  = wr_en && !rd_busy;
    assign rd_key = key_q[rd_idx];

    for (genvar s = 0; s < KEY_SLOTS; s++) begin : g_slot
        always_comb begin
            key_d[s] = key_q[s];
            if (erase) begin
                key_d[s] = '1;
            end else if (wr_ok && (wr_idx == KEY_IDX_W'(s))) begin
                key_d[s] = key_q[s] & wr_data;
            end
        end

        always_ff @(posedge clk) begin
            key_q[s] <= key_d[s];
        end

        AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (rst)
            erase |=> (key_q[s] == '1)) else $error("erase left a slot non-blank"); // R3

        AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
            !erase |=> ((key_q[s] & ~$past(key_q[s])) == '0)) else $error("key bit set without erase"); // R6

        AST_READ_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
            (rd_busy && !erase) |=> $stable(key_q[s])) else $error("key changed during read"); // R5
    end
endmodule

// File: rtl/scr_code_ram.sv
module scr_code_ram
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/scr_readout.sv
module scr_readout
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [DATA_W-1:0] key_byte,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        if (req) begin
            st_d.data = mem_byte ^ ~key_byte;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        req |=> valid_o) else $error("valid missing after request"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!valid_o && $stable(data_o))) else $error("output moved while idle"); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!valid_o && data_o == '0)) else $error("reset left output set"); // R8

    AST_BLANK_LEAKS_KEY: assert property (@(posedge clk) disable iff (rst)
        (req && mem_byte == '1) |=> (data_o == $past(key_byte))) else $error("0xFF byte did not expose key"); // R7
endmodule

// File: rtl/code_scrambler.sv
module code_scrambler
    import scr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mem_we,
    input  logic [ADDR_W-1:0]    mem_waddr,
    input  logic [DATA_W-1:0]    mem_wdata,
    input  logic                 key_we,
    input  logic [KEY_IDX_W-1:0] key_idx,
    input  logic [DATA_W-1:0]    key_wdata,
    input  logic                 erase,
    input  logic                 rd_req,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);
    logic [DATA_W-1:0] mem_byte;
    logic [DATA_W-1:0] key_byte;

    scr_code_ram u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (mem_byte)
    );

    scr_key_table u_keys (
        .clk     (clk),
        .rst     (rst),
        .erase   (erase),
        .wr_en   (key_we),
        .wr_idx  (key_idx),
        .wr_data (key_wdata),
        .rd_busy (rd_req),
        .rd_idx  (rd_addr[KEY_IDX_W-1:0]),
        .rd_key  (key_byte)
    );

    scr_readout u_out (
        .clk      (clk),
        .rst      (rst),
        .req      (rd_req),
        .mem_byte (mem_byte),
        .key_byte (key_byte),
        .data_o   (rd_data),
        .valid_o  (rd_valid)
    );
endmodule

// File: tb/code_scrambler_tb.sv
module code_scrambler_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_we = 1'b0;
    logic [11:0] mem_waddr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        key_we = 1'b0;
    logic [5:0]  key_idx = '0;
    logic [7:0]  key_wdata = '0;
    logic        erase = 1'b0;
    logic        rd_req = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    code_scrambler dut_i (
        .clk(clk), .rst(rst),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .key_we(key_we), .key_idx(key_idx), .key_wdata(key_wdata),
        .erase(erase), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // {address[11:0], stored byte, key byte, expected readout}
    localparam logic [35:0] VEC [8] = '{
        {12'h000, 8'h00, 8'hFF, 8'h00},
        {12'h001, 8'h5A, 8'h00, 8'hA5},
        {12'h03F, 8'h12, 8'hF0, 8'h1D},
        {12'h7C5, 8'hFF, 8'h3C, 8'h3C},
        {12'hFFF, 8'h80, 8'h7F, 8'h00},
        {12'h440, 8'hA5, 8'h96, 8'hCC},
        {12'h123, 8'hC3, 8'hAA, 8'h96},
        {12'h2BE, 8'hFF, 8'h01, 8'h01}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic mem_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
        @(negedge clk); mem_we = 1'b0;
    endtask

    task automatic key_wr(input logic [5:0] i, input logic [7:0] d);
        @(negedge clk); key_we = 1'b1; key_idx = i; key_wdata = d;
        @(negedge clk); key_we = 1'b0;
    endtask

    task automatic erase_all();
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
    endtask

    task automatic read_exp(input string tag, input logic [11:0] a, input logic [7:0] exp);
        @(negedge clk); rd_req = 1'b1; rd_addr = a;
        @(negedge clk); rd_req = 1'b0;
        chk({tag, " valid"}, {7'b0, rd_valid}, 8'h01);
        chk(tag, rd_data, exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset valid", {7'b0, rd_valid}, 8'h00);
        chk("R8 reset data", rd_data, 8'h00);
        rst = 1'b0;

        // R1 R7 vector table
        for (int v = 0; v < 8; v++) begin
            erase_all();
            key_wr(VEC[v][29:24], VEC[v][15:8]);
            mem_wr(VEC[v][35:24], VEC[v][23:16]);
            read_exp((VEC[v][23:16] == 8'hFF) ? "R7 leak" : "R1 vector", VEC[v][35:24], VEC[v][7:0]);
        end

        // R4 idle cycle after a read: valid drops, data held
        @(negedge clk);
        chk("R4 idle valid", {7'b0, rd_valid}, 8'h00);
        chk("R4 idle hold", rd_data, 8'h01);

        // R2 wrap across the address space
        erase_all();
        mem_wr(12'h003, 8'h11);
        mem_wr(12'hFC3, 8'h22);
        key_wr(6'd3, 8'h0F);
        read_exp("R2 low", 12'h003, 8'hE1);
        read_exp("R2 high", 12'hFC3, 8'hD2);

        // R6 writes only clear bits: 0x0F & 0xF3 = 0x03
        key_wr(6'd3, 8'hF3);
        read_exp("R6 and", 12'h003, 8'hED);

        // R5 key write during read is dropped
        @(negedge clk); rd_req = 1'b1; rd_addr = 12'h003; key_we = 1'b1; key_idx = 6'd3; key_wdata = 8'h00;
        @(negedge clk); rd_req = 1'b0; key_we = 1'b0;
        chk("R5 same cycle", rd_data, 8'hED);
        read_exp("R5 after", 12'h003, 8'hED);

        // R3 erase gives passthrough
        erase_all();
        read_exp("R3 low", 12'h003, 8'h11);
        read_exp("R3 high", 12'hFC3, 8'h22);

        // R10 read with erase uses old key (slot 3 = 0x00)
        key_wr(6'd3, 8'h00);
        @(negedge clk); rd_req = 1'b1; rd_addr = 12'h003; erase = 1'b1;
        @(negedge clk); rd_req = 1'b0; erase = 1'b0;
        chk("R10 old key", rd_data, 8'hEE);
        read_exp("R10 after", 12'h003, 8'h11);

        // R9 erase beats a same-cycle key write
        @(negedge clk); erase = 1'b1; key_we = 1'b1; key_idx = 6'd3; key_wdata = 8'h00;
        @(negedge clk); erase = 1'b0; key_we = 1'b0;
        read_exp("R9 erase wins", 12'h003, 8'h11);

        // R8 reset keeps key and memory
        key_wr(6'd3, 8'h0F);
        read_exp("R8 pre", 12'h003, 8'hE1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R8 mid valid", {7'b0, rd_valid}, 8'h00);
        chk("R8 mid data", rd_data, 8'h00);
        read_exp("R8 retained", 12'h003, 8'hE1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule